// File: doc/BRIEF.md
# System Tick Down Counter

A programmable periodic timer built around a 24-bit down counter. Software programs a reload value, selects whether the counter steps on every processor clock or only on cycles where a synchronous reference tick is high, and enables it. On each expiry the counter reloads itself, sets a sticky expiry flag, and can send a one-cycle request to the interrupt arbiter.

Four word registers are reached through a simple port: a write strobe with data, and an address-selected read value. The read value is combinational. A read strobe marks a read that has a side effect: on the control register it clears the expiry flag. A reload value of zero gives a one-shot timer. The counter expires once and then switches itself off.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current registers read 0 and `tick_req` is low.
- R2: Register select `addr`: 0 control, 1 reload, 2 current value, 3 calibration. Control bit 0 is run, bit 1 is request enable, bit 2 is source (1 = every clock, 0 = reference tick). Bit 16 is the read-only expiry flag. Only bits 2:0 take written data, and all other bits read 0.
- R3: A control write that sets run while run is 0 loads the current value from the reload register. The counter then decrements once per step and expires on the step taken at 0, so one period is reload + 1 steps.
- R4: An expiry sets the expiry flag. If request enable is 1, `tick_req` is high for the one cycle after the expiring edge. If request enable is 0, `tick_req` stays low.
- R5: If the reload register is 0 at expiry, run clears itself and no further expiry occurs. Otherwise the counter reloads and keeps running.
- R6: A control read with `rd_en` high returns the flag and then clears it. An expiry in the same cycle as that read leaves the flag set.
- R7: A write of any data to the current-value register restarts the count from the reload value and clears the expiry flag.
- R8: The current-value register reads 0 while run is 0.
- R9: A control write that keeps run at 1 but changes the source bit reloads the counter from the reload register.
- R10: In reference mode the counter changes only on cycles where `ref_tick` is 1. In clock mode it decrements on every cycle.
- R11: The calibration register reads the constant 10000.
- R12: The reload register keeps the low 24 bits of written data, and bits 31:24 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Marks a read with side effect (flag clear) |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| ref_tick | input | 1 | Reference clock enable, synchronous to clk |
| tick_req | output | 1 | One-cycle pending request to the interrupt arbiter |

## Verification
Several rules are checked by assertions on every cycle:
- A request only follows an expiry with request enable set.
- The flag is always set while a request is high.
- A zero-reload expiry leaves the timer stopped.
- The current value reads zero when stopped.
- In reference mode the count holds without a tick.
- In clock mode the count drops by exactly one per cycle.

Other behaviour needs the bench's scenarios:
- The exact period and the cycle in which the request appears.
- The read-then-clear order of the flag, and its collision with an expiry.
- Restart on a current-value write or a source change.
- Masking of the control and reload fields.
- The calibration constant.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_CURR   = 2'd2,
      SEL_CALIB  = 2'd3
   } reg_sel_e;

   localparam int CTL_RUN  = 0;
   localparam int CTL_INT  = 1;
   localparam int CTL_SRC  = 2;
   localparam int CTL_FLAG = 16;

   typedef struct packed {
      logic src;
      logic inten;
      logic run;
   } ctl_t;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
   import tick_timer_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_rld,
   input  logic             wr_cur,
   input  logic             rd_ctrl,
   input  logic [2:0]       ctl_wdata,
   input  logic [CNT_W-1:0] rld_wdata,
   input  logic             expire,
   output ctl_t             ctl,
   output logic             flag,
   output logic [CNT_W-1:0] reload,
   output logic             load
);
   logic run_rise;
   logic src_swap;

   assign run_rise = wr_ctrl & ~ctl.run & ctl_wdata[CTL_RUN];
   assign src_swap = wr_ctrl & ctl.run & ctl_wdata[CTL_RUN]
                     & (ctl_wdata[CTL_SRC] != ctl.src);
   assign load     = run_rise | src_swap | wr_cur;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl    <= '0;
         flag   <= 1'b0;
         reload <= '0;
      end else begin
         if (wr_ctrl) begin
            ctl.run   <= ctl_wdata[CTL_RUN];
            ctl.inten <= ctl_wdata[CTL_INT];
            ctl.src   <= ctl_wdata[CTL_SRC];
         end else if (expire && (reload == '0)) begin
            ctl.run <= 1'b0;
         end
         if (wr_rld) reload <= rld_wdata;
         if (expire) flag <= 1'b1;
         else if (rd_ctrl || wr_cur) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/tick_timer_step.sv
module tick_timer_step #(
   parameter bit HAS_REF = 1'b1
) (
   input  logic run,
   input  logic src,
   input  logic ref_tick,
   output logic step
);
   generate
      if (HAS_REF) begin : g_sel
         assign step = run & (src | ref_tick);
      end else begin : g_clk_only
         logic unused_ref;
         assign unused_ref = src ^ ref_tick;
         assign step = run;
      end
   endgenerate
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic             inten,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cur,
   output logic             expire,
   output logic             tick_req
);
   logic at_zero;

   assign at_zero = (cur == '0);
   assign expire  = step & ~load & at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur      <= '0;
         tick_req <= 1'b0;
      end else begin
         if (load) cur <= reload;
         else if (step) cur <= at_zero ? reload : cur - 1'b1;
         tick_req <= expire & inten;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 24,
   parameter int CAL_VALUE = 10000,
   parameter bit HAS_REF   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              ref_tick,
   output logic              tick_req
);
   localparam int HI_W = DATA_W - CNT_W;

   generate
      if (CNT_W < 2 || CNT_W >= DATA_W) begin : g_bad_cnt
         $error("tick_timer: CNT_W must be in 2..DATA_W-1");
      end
      if (CTL_FLAG >= DATA_W) begin : g_bad_flag
         $error("tick_timer: DATA_W too narrow for flag bit");
      end
      if (CAL_VALUE < 0 || CAL_VALUE >= (1 << CNT_W)) begin : g_bad_cal
         $error("tick_timer: CAL_VALUE does not fit the counter");
      end
   endgenerate

   reg_sel_e         sel;
   logic             wr_ctrl, wr_rld, wr_cur, rd_ctrl;
   ctl_t             ctl;
   logic             flag, load, step, expire;
   logic [CNT_W-1:0] reload, cur;
   logic             run_q, inten_q, src_q;
   logic             unused_wdata_hi;

   assign sel     = reg_sel_e'(addr);
   assign wr_ctrl = wr_en && (sel == SEL_CTRL);
   assign wr_rld  = wr_en && (sel == SEL_RELOAD);
   assign wr_cur  = wr_en && (sel == SEL_CURR);
   assign rd_ctrl = rd_en && (sel == SEL_CTRL);
   assign run_q   = ctl.run;
   assign inten_q = ctl.inten;
   assign src_q   = ctl.src;
   assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

   tick_timer_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wr_rld   (wr_rld),
      .wr_cur   (wr_cur),
      .rd_ctrl  (rd_ctrl),
      .ctl_wdata(wdata[2:0]),
      .rld_wdata(wdata[CNT_W-1:0]),
      .expire   (expire),
      .ctl      (ctl),
      .flag     (flag),
      .reload   (reload),
      .load     (load)
   );

   tick_timer_step #(.HAS_REF(HAS_REF)) u_step (
      .run     (run_q),
      .src     (src_q),
      .ref_tick(ref_tick),
      .step    (step)
   );

   tick_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .load    (load),
      .inten   (inten_q),
      .reload  (reload),
      .cur     (cur),
      .expire  (expire),
      .tick_req(tick_req)
   );

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CTRL: begin
            rdata[CTL_FLAG] = flag;
            rdata[CTL_SRC]  = src_q;
            rdata[CTL_INT]  = inten_q;
            rdata[CTL_RUN]  = run_q;
         end
         SEL_RELOAD: rdata = {{HI_W{1'b0}}, reload};
         SEL_CURR:   rdata = run_q ? {{HI_W{1'b0}}, cur} : '0;
         default:    rdata = DATA_W'(CAL_VALUE);
      endcase
   end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 24,
   parameter bit HAS_REF = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] rdata,
   input logic              ref_tick,
   input logic              tick_req,
   input logic              run,
   input logic              inten,
   input logic              src,
   input logic              flag,
   input logic [CNT_W-1:0]  cur,
   input logic [CNT_W-1:0]  reload
);
   AST_REQ_NEEDS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      tick_req |-> $past(inten)); // R4

   AST_REQ_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      tick_req |-> flag); // R6

   AST_ZERO_RELOAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_req && ($past(reload) == '0) && !$past(wr_en)) |-> !run); // R5

   AST_CUR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && (addr == 2'd2)) |-> (rdata == '0)); // R8

   AST_CLK_MODE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && $past(src) && !$past(wr_en) && ($past(cur) != '0))
      |-> (cur == $past(cur) - 1'b1)); // R10

   generate
      if (HAS_REF) begin : g_ref
         AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(src) && !$past(ref_tick) && !$past(wr_en))
            |-> (cur == $past(cur))); // R10
      end
   endgenerate
endmodule

bind tick_timer tick_timer_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .HAS_REF(HAS_REF)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .rdata   (rdata),
   .ref_tick(ref_tick),
   .tick_req(tick_req),
   .run     (run_q),
   .inten   (inten_q),
   .src     (src_q),
   .flag    (flag),
   .cur     (cur),
   .reload  (reload)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ref_tick = 1'b0;
   logic        tick_req;

   int total = 0;
   int bad = 0;
   int req_cnt = 0;
   bit done = 1'b0;

   tick_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ref_tick(ref_tick), .tick_req(tick_req)
   );

   always #5 clk = ~clk;

   always @(negedge clk) if (rst_n && tick_req) req_cnt++;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic rd_clear(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic ref_steps(input int n);
      repeat (n) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      peek(2'd0, v); check("R1 ctrl", v, 32'h0);
      peek(2'd1, v); check("R1 reload", v, 32'h0);
      peek(2'd2, v); check("R1 current", v, 32'h0);
      check("R1 tick_req", {31'b0, tick_req}, 32'h0);
      peek(2'd3, v); check("R11 calib", v, 32'd10000);
   endtask

   task automatic t_fields;
      logic [31:0] v;
      wr(2'd0, 32'hFFFF_FFFA);
      peek(2'd0, v); check("R2 ctrl mask", v, 32'h2);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'hFF12_3456);
      peek(2'd1, v); check("R12 reload mask", v, 32'h0012_3456);
   endtask

   task automatic t_ref_count;
      logic [31:0] v;
      int r0;
      wr(2'd1, 32'd5);
      wr(2'd0, 32'h1);
      peek(2'd2, v); check("R3 load on enable", v, 32'd5);
      repeat (3) @(negedge clk);
      peek(2'd2, v); check("R10 hold without ref_tick", v, 32'd5);
      ref_steps(2);
      peek(2'd2, v); check("R3 count down", v, 32'd3);
      ref_steps(3);
      peek(2'd2, v); check("R3 reaches zero", v, 32'd0);
      r0 = req_cnt;
      ref_steps(1);
      peek(2'd2, v); check("R5 reload after expiry", v, 32'd5);
      repeat (2) @(negedge clk);
      check("R4 no request when masked", req_cnt - r0, 32'd0);
      rd_clear(2'd0, v); check("R6 flag read", v, 32'h0001_0001);
      rd_clear(2'd0, v); check("R6 flag cleared", v, 32'h1);
   endtask

   task automatic t_request;
      logic [31:0] v;
      int r0;
      wr(2'd0, 32'h0);
      wr(2'd1, 32'd2);
      wr(2'd0, 32'h3);
      ref_steps(2);
      r0 = req_cnt;
      check("R4 no early request", req_cnt - r0, 32'd0);
      ref_steps(1);
      repeat (3) @(negedge clk);
      check("R4 one-cycle request", req_cnt - r0, 32'd1);
      peek(2'd0, v); check("R5 still running", v, 32'h0001_0003);
      peek(2'd2, v); check("R5 reloaded", v, 32'd2);
   endtask

   task automatic t_one_shot;
      logic [31:0] v;
      int r0;
      wr(2'd0, 32'h0);
      wr(2'd1, 32'd0);
      wr(2'd0, 32'h3);
      r0 = req_cnt;
      ref_steps(1);
      repeat (2) @(negedge clk);
      check("R5 one-shot request", req_cnt - r0, 32'd1);
      peek(2'd0, v); check("R5 run cleared", v, 32'h0001_0002);
      ref_steps(2);
      check("R5 no further expiry", req_cnt - r0, 32'd1);
      peek(2'd2, v); check("R8 stopped reads zero", v, 32'd0);
   endtask

   task automatic t_cur_write;
      logic [31:0] v;
      wr(2'd1, 32'd3);
      wr(2'd0, 32'h1);
      ref_steps(2);
      peek(2'd2, v); check("R7 before restart", v, 32'd1);
      wr(2'd2, 32'h0000_0ABC);
      peek(2'd2, v); check("R7 restart value", v, 32'd3);
      peek(2'd0, v); check("R7 flag cleared", v, 32'h1);
      wr(2'd0, 32'h0);
      peek(2'd2, v); check("R8 disabled reads zero", v, 32'd0);
   endtask

   task automatic t_src_change;
      logic [31:0] v;
      wr(2'd1, 32'd9);
      wr(2'd0, 32'h1);
      ref_steps(4);
      peek(2'd2, v); check("R10 ref steps", v, 32'd5);
      wr(2'd0, 32'h5);
      peek(2'd2, v); check("R9 reload on source change", v, 32'd9);
      @(negedge clk);
      peek(2'd2, v); check("R10 clock mode step 1", v, 32'd8);
      @(negedge clk);
      peek(2'd2, v); check("R10 clock mode step 2", v, 32'd7);
      wr(2'd0, 32'h0);
   endtask

   task automatic t_clk_period;
      logic [31:0] v;
      wr(2'd1, 32'd3);
      wr(2'd0, 32'h7);
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         check("R3 no request before period end", {31'b0, tick_req}, 32'h0);
      end
      @(negedge clk);
      check("R3 request after reload+1 cycles", {31'b0, tick_req}, 32'h1);
      peek(2'd2, v); check("R3 reload at period end", v, 32'd3);
      @(negedge clk);
      check("R4 request drops", {31'b0, tick_req}, 32'h0);
      wr(2'd0, 32'h0);
   endtask

   task automatic t_read_collision;
      logic [31:0] v;
      wr(2'd1, 32'd1);
      wr(2'd0, 32'h1);
      rd_clear(2'd0, v);
      ref_steps(1);
      @(negedge clk); addr = 2'd0; rd_en = 1'b1; ref_tick = 1'b1; #1; v = rdata;
      check("R6 flag clear before collision", v, 32'h1);
      @(negedge clk); rd_en = 1'b0; ref_tick = 1'b0;
      peek(2'd0, v); check("R6 expiry wins over read clear", v, 32'h0001_0001);
      wr(2'd0, 32'h0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_ref_count();
      t_request();
      t_one_shot();
      t_cur_write();
      t_src_change();
      t_clk_period();
      t_read_collision();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule